// File: doc/BRIEF.md
# Multicast TLP Group Decoder

This block sits in front of one egress port of a packet switch and decides, for each incoming memory-request header, whether the header is a multicast copy bound for this port. Software programs a power-of-two address window that is cut into up to 64 equally sized groups. A memory write that lands in that window is given a group number. Three per-group masks then decide whether this port emits the copy: the receive mask, the block-all mask and the block-untranslated mask.

For endpoints that cannot decode multicast addresses, an overlay register can replace the upper address bits with a unicast window, keeping only the low bits of the original address. Headers that are not multicast hits pass straight through. They keep their address unchanged and take their forward decision from the unicast routing input. All results are registered and appear one cycle after the header strobe.

Configuration is written through a small select/data port, one 64-bit register per select code. A write lands at the clock edge. A header presented in the same cycle as a register write is therefore decoded with the old settings.

Top module: `mc_group_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_hit`, `out_fwd` are 0, `out_group` is 0 and `out_addr` is 0 until the first header is strobed.
- R2: `out_valid` is high exactly one cycle after `hdr_valid`, and the registered outputs in that cycle describe the header strobed in the previous cycle.
- R3: A header is a hit only when all of these hold: control bit 31 (enable) is set, `hdr_write` is 1, and the address lies inside the window of all configured groups.
- R4: The group number is (address − base) >> index_position. Base is bits 63:12 of the base register (select 1) with the low 12 bits taken as zero, and index_position is bits 5:0 of the same register. An address below the base is not a hit.
- R5: Control bits 21:16 hold N and configure N+1 groups (0 means one group, 63 means 64). An address whose group number exceeds N is not a hit.
- R6: An index_position below 12 disables all multicast decoding. A value of 11 never hits, and a value of 12 decodes 4 KiB groups.
- R7: A hit is forwarded only if bit g of the receive mask (select 2) is set, where g is the decoded group.
- R8: Bit g of the block-all mask (select 3) drops every copy of group g, even when the receive bit is set.
- R9: Bit g of the block-untranslated mask (select 4) drops copies of group g whose `hdr_translated` is 0. It has no effect when `hdr_translated` is 1.
- R10: The overlay register (select 5) holds a size in bits 5:0 and a replacement address in bits 63:6. For a hit with size ≥ 6, the low `size` bits of `out_addr` come from the header address and the rest come from the replacement address. With size < 6, the address is unchanged.
- R11: For a non-hit, `out_hit` is 0, `out_group` is 0, `out_fwd` equals `uc_route` and `out_addr` equals the header address.
- R12: A register write (select 0 = control) in the same cycle as a header strobe does not affect that header. It applies from the next header on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 base, 2 receive, 3 block-all, 4 block-untranslated, 5 overlay |
| cfg_wdata | input | 64 | Register write data |
| hdr_valid | input | 1 | Header strobe |
| hdr_addr | input | 64 | Request address |
| hdr_write | input | 1 | 1 for a memory write request |
| hdr_translated | input | 1 | 1 when the address is already translated |
| uc_route | input | 1 | Forward decision for non-multicast traffic |
| out_valid | output | 1 | Result strobe, one cycle after `hdr_valid` |
| out_hit | output | 1 | Header decoded as a multicast copy |
| out_group | output | 6 | Decoded group number (0 on a miss) |
| out_fwd | output | 1 | Emit the header at this port |
| out_addr | output | 64 | Outgoing, possibly overlaid, address |

## Verification
Addresses are placed on both sides of each group edge: the first and last byte of a group, one byte below the base, and the first byte past the last configured group. These points separate off-by-one errors in the subtraction, in the shift and in the count comparison. The mask tests combine receive, block-all and block-untranslated bits on the same group with the translated flag toggled, so that a wrong precedence order shows up as a forwarded or dropped copy. Index positions 11 and 12, and overlay sizes 5, 6 and 63, pin down the two disable thresholds and the full-width splice. A control write in the same cycle as a header separates register timing from decode timing.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int ADDR_W   = 64;
  localparam int GRP_MAX  = 64;
  localparam int GRP_W    = $clog2(GRP_MAX);
  localparam int SIZE_W   = 6;
  localparam int SEL_W    = 3;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
  localparam logic [SEL_W-1:0] SEL_BASE = 3'd1;
  localparam logic [SEL_W-1:0] SEL_RCV  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_BALL = 3'd3;
  localparam logic [SEL_W-1:0] SEL_BUNT = 3'd4;
  localparam logic [SEL_W-1:0] SEL_OVL  = 3'd5;

  localparam int CTRL_EN_BIT = 31;
  localparam int CTRL_CNT_LO = 16;
  localparam int BASE_LO     = 12;
  localparam int MIN_IDX     = 12;
  localparam int MIN_OVL     = 6;

  // Group number of an address relative to a window base; wide result.
  function automatic logic [ADDR_W-1:0] grp_index(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] b,
                                                  input logic [SIZE_W-1:0] sh);
    logic [ADDR_W-1:0] diff;
    diff = a - b;
    return diff >> sh;
  endfunction

  // Keep the low 'sz' bits of a, take the rest from r.
  function automatic logic [ADDR_W-1:0] ovl_splice(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] r,
                                                   input logic [SIZE_W-1:0] sz);
    logic [ADDR_W-1:0] keep;
    keep = ({{(ADDR_W-1){1'b0}}, 1'b1} << sz) - 1'b1;
    return (a & keep) | (r & ~keep);
  endfunction
endpackage

// File: rtl/mcd_regs.sv
module mcd_regs
  import mcd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic [ADDR_W-1:0]      cfg_wdata,
  output logic                   cfg_enable,
  output logic [GRP_W-1:0]       grp_last,
  output logic [ADDR_W-1:0]      base_addr,
  output logic [SIZE_W-1:0]      idx_pos,
  output logic [GRP_MAX-1:0]     rcv_mask,
  output logic [GRP_MAX-1:0]     ball_mask,
  output logic [GRP_MAX-1:0]     bunt_mask,
  output logic [SIZE_W-1:0]      ovl_size,
  output logic [ADDR_W-1:0]      ovl_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_enable <= 1'b0;
      grp_last   <= '0;
      base_addr  <= '0;
      idx_pos    <= '0;
      rcv_mask   <= '0;
      ball_mask  <= '0;
      bunt_mask  <= '0;
      ovl_size   <= '0;
      ovl_addr   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_CTRL: begin
          cfg_enable <= cfg_wdata[CTRL_EN_BIT];
          grp_last   <= cfg_wdata[CTRL_CNT_LO +: GRP_W];
        end
        SEL_BASE: begin
          base_addr <= {cfg_wdata[ADDR_W-1:BASE_LO], {BASE_LO{1'b0}}};
          idx_pos   <= cfg_wdata[SIZE_W-1:0];
        end
        SEL_RCV:  rcv_mask  <= cfg_wdata[GRP_MAX-1:0];
        SEL_BALL: ball_mask <= cfg_wdata[GRP_MAX-1:0];
        SEL_BUNT: bunt_mask <= cfg_wdata[GRP_MAX-1:0];
        SEL_OVL: begin
          ovl_size <= cfg_wdata[SIZE_W-1:0];
          ovl_addr <= {cfg_wdata[ADDR_W-1:MIN_OVL], {MIN_OVL{1'b0}}};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mcd_match.sv
module mcd_match
  import mcd_pkg::*;
(
  input  logic                   cfg_enable,
  input  logic [GRP_W-1:0]       grp_last,
  input  logic [ADDR_W-1:0]      base_addr,
  input  logic [SIZE_W-1:0]      idx_pos,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   is_write,
  output logic                   hit,
  output logic [GRP_W-1:0]       group
);
  logic              idx_ok;
  logic              above;
  logic [ADDR_W-1:0] gnum;
  logic              in_count;

  always_comb begin
    idx_ok   = (idx_pos >= SIZE_W'(MIN_IDX));
    above    = (addr >= base_addr);
    gnum     = grp_index(addr, base_addr, idx_pos);
    in_count = (gnum <= ADDR_W'(grp_last));
    hit      = cfg_enable && is_write && idx_ok && above && in_count;
    group    = hit ? gnum[GRP_W-1:0] : '0;
  end
endmodule

// File: rtl/mcd_filter.sv
module mcd_filter
  import mcd_pkg::*;
(
  input  logic                   hit,
  input  logic [GRP_W-1:0]       group,
  input  logic                   translated,
  input  logic                   uc_route,
  input  logic [GRP_MAX-1:0]     rcv_mask,
  input  logic [GRP_MAX-1:0]     ball_mask,
  input  logic [GRP_MAX-1:0]     bunt_mask,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [SIZE_W-1:0]      ovl_size,
  input  logic [ADDR_W-1:0]      ovl_addr,
  output logic                   fwd,
  output logic [ADDR_W-1:0]      addr_out
);
  logic want, blocked_all, blocked_unt, ovl_on;

  always_comb begin
    want        = rcv_mask[group];
    blocked_all = ball_mask[group];
    blocked_unt = bunt_mask[group] && !translated;
    fwd         = hit ? (want && !blocked_all && !blocked_unt) : uc_route;
    ovl_on      = hit && (ovl_size >= SIZE_W'(MIN_OVL));
    addr_out    = ovl_on ? ovl_splice(addr, ovl_addr, ovl_size) : addr;
  end
endmodule

// File: rtl/mc_group_decoder.sv
module mc_group_decoder
  import mcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [63:0]        cfg_wdata,
  input  logic               hdr_valid,
  input  logic [63:0]        hdr_addr,
  input  logic               hdr_write,
  input  logic               hdr_translated,
  input  logic               uc_route,
  output logic               out_valid,
  output logic               out_hit,
  output logic [5:0]         out_group,
  output logic               out_fwd,
  output logic [63:0]        out_addr
);
  logic               cfg_enable;
  logic [GRP_W-1:0]   grp_last;
  logic [ADDR_W-1:0]  base_addr;
  logic [SIZE_W-1:0]  idx_pos;
  logic [GRP_MAX-1:0] rcv_mask, ball_mask, bunt_mask;
  logic [SIZE_W-1:0]  ovl_size;
  logic [ADDR_W-1:0]  ovl_addr;

  logic               dec_hit;
  logic [GRP_W-1:0]   dec_group;
  logic               dec_fwd;
  logic [ADDR_W-1:0]  dec_addr;

  mcd_regs regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_enable(cfg_enable), .grp_last(grp_last),
    .base_addr(base_addr), .idx_pos(idx_pos), .rcv_mask(rcv_mask),
    .ball_mask(ball_mask), .bunt_mask(bunt_mask), .ovl_size(ovl_size),
    .ovl_addr(ovl_addr)
  );

  mcd_match match_i (
    .cfg_enable(cfg_enable), .grp_last(grp_last), .base_addr(base_addr),
    .idx_pos(idx_pos), .addr(hdr_addr), .is_write(hdr_write),
    .hit(dec_hit), .group(dec_group)
  );

  mcd_filter filt_i (
    .hit(dec_hit), .group(dec_group), .translated(hdr_translated),
    .uc_route(uc_route), .rcv_mask(rcv_mask), .ball_mask(ball_mask),
    .bunt_mask(bunt_mask), .addr(hdr_addr), .ovl_size(ovl_size),
    .ovl_addr(ovl_addr), .fwd(dec_fwd), .addr_out(dec_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_group <= '0;
      out_fwd   <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= hdr_valid;
      if (hdr_valid) begin
        out_hit   <= dec_hit;
        out_group <= dec_group;
        out_fwd   <= dec_fwd;
        out_addr  <= dec_addr;
      end
    end
  end
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_valid,
  input logic [63:0] hdr_addr,
  input logic        hdr_write,
  input logic        hdr_translated,
  input logic        uc_route,
  input logic        cfg_enable,
  input logic [5:0]  grp_last,
  input logic [5:0]  idx_pos,
  input logic [63:0] rcv_mask,
  input logic [63:0] ball_mask,
  input logic [63:0] bunt_mask,
  input logic        out_valid,
  input logic        out_hit,
  input logic [5:0]  out_group,
  input logic        out_fwd,
  input logic [63:0] out_addr
);
  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(hdr_valid));
  // R3
  hit_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> ($past(cfg_enable) && $past(hdr_write)));
  // R5
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (out_group <= $past(grp_last)));
  // R6
  idx_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> ($past(idx_pos) >= 6'd12));
  // R7
  recv_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit && out_fwd) |-> ((($past(rcv_mask) >> out_group) & 64'd1) != 64'd0));
  // R8
  block_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit && out_fwd) |-> ((($past(ball_mask) >> out_group) & 64'd1) == 64'd0));
  // R9
  block_unt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit && out_fwd && !$past(hdr_translated)) |->
      ((($past(bunt_mask) >> out_group) & 64'd1) == 64'd0));
  // R11
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |->
      (out_fwd == $past(uc_route) && out_addr == $past(hdr_addr) && out_group == 6'd0));
endmodule

bind mc_group_decoder mcd_checker chk_i (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_addr(hdr_addr),
  .hdr_write(hdr_write), .hdr_translated(hdr_translated), .uc_route(uc_route),
  .cfg_enable(cfg_enable), .grp_last(grp_last), .idx_pos(idx_pos),
  .rcv_mask(rcv_mask), .ball_mask(ball_mask), .bunt_mask(bunt_mask),
  .out_valid(out_valid), .out_hit(out_hit), .out_group(out_group),
  .out_fwd(out_fwd), .out_addr(out_addr)
);

// File: tb/mc_group_decoder_tb_top.sv
module mc_group_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic        hdr_valid = 1'b0;
  logic [63:0] hdr_addr = '0;
  logic        hdr_write = 1'b0;
  logic        hdr_translated = 1'b0;
  logic        uc_route = 1'b0;
  logic        out_valid, out_hit, out_fwd;
  logic [5:0]  out_group;
  logic [63:0] out_addr;

  int n_chk = 0;
  int n_bad = 0;

  // Shadow configuration held by the bench
  bit          s_en;
  int          s_cnt;
  logic [63:0] s_base;
  int          s_idx;
  logic [63:0] s_rcv, s_ball, s_bunt;
  int          s_osz;
  logic [63:0] s_orep;

  always #2 clk = ~clk;

  mc_group_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .hdr_valid(hdr_valid), .hdr_addr(hdr_addr),
    .hdr_write(hdr_write), .hdr_translated(hdr_translated), .uc_route(uc_route),
    .out_valid(out_valid), .out_hit(out_hit), .out_group(out_group),
    .out_fwd(out_fwd), .out_addr(out_addr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void shadow(input logic [2:0] sel, input logic [63:0] d);
    case (sel)
      3'd0: begin s_en = d[31]; s_cnt = int'(d[21:16]); end
      3'd1: begin s_base = d & ~64'hFFF; s_idx = int'(d[5:0]); end
      3'd2: s_rcv = d;
      3'd3: s_ball = d;
      3'd4: s_bunt = d;
      3'd5: begin s_osz = int'(d[5:0]); s_orep = d & ~64'h3F; end
      default: ;
    endcase
  endfunction

  task automatic wr_reg(input logic [2:0] sel, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow(sel, d);
  endtask

  // Reference: scan group windows one by one.
  function automatic void ref_model(input logic [63:0] a, input bit w, input bit tr,
                                    input bit uc, output bit h, output int g,
                                    output bit f, output logic [63:0] oa);
    h = 0; g = 0; f = uc; oa = a;
    if (s_en && w && s_idx >= 12) begin
      for (int k = 0; k <= s_cnt; k++) begin
        logic [63:0] lo, span;
        span = 64'd1 << s_idx;
        lo = s_base + span * 64'(k);
        if (a >= lo && a - lo < span) begin h = 1; g = k; end
      end
    end
    if (h) begin
      f = s_rcv[g] && !s_ball[g] && !(s_bunt[g] && !tr);
      if (s_osz >= 6)
        for (int b = 0; b < 64; b++) oa[b] = (b < s_osz) ? a[b] : s_orep[b];
    end
  endfunction

  task automatic send(input string req, input logic [63:0] a, input bit w,
                      input bit tr, input bit uc);
    bit h, f; int g; logic [63:0] oa;
    ref_model(a, w, tr, uc, h, g, f, oa);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_addr = a; hdr_write = w; hdr_translated = tr; uc_route = uc;
    @(negedge clk);
    hdr_valid = 1'b0;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " hit"},   64'(out_hit),   64'(h));
    check({req, " group"}, 64'(out_group), 64'(g));
    check({req, " fwd"},   64'(out_fwd),   64'(f));
    check({req, " addr"},  out_addr,       oa);
  endtask

  task automatic t_reset;
    check("R1 valid", 64'(out_valid), 64'd0);
    check("R1 hit",   64'(out_hit),   64'd0);
    check("R1 fwd",   64'(out_fwd),   64'd0);
    check("R1 addr",  out_addr,       64'd0);
  endtask

  task automatic t_groups;
    wr_reg(3'd0, 64'h8002_803F);
    wr_reg(3'd1, 64'h0780_0014);
    wr_reg(3'd2, 64'h7);
    send("R4 first", 64'h0780_0000, 1, 1, 0);
    send("R4 g1", 64'h079F_FFFF, 1, 1, 0);
    send("R4 g2", 64'h07A0_0000, 1, 1, 0);
    send("R5 last byte", 64'h07AF_FFFF, 1, 1, 0);
    send("R5 past count", 64'h07B0_0000, 1, 1, 1);
    send("R4 below base", 64'h077F_FFFF, 1, 1, 1);
    check("R5 past count miss", 64'(out_hit), 64'd0);
  endtask

  task automatic t_conditions;
    send("R3 read", 64'h0790_0000, 0, 1, 1);
    check("R11 read addr kept", out_addr, 64'h0790_0000);
    wr_reg(3'd0, 64'h0002_0000);
    send("R3 disabled", 64'h0790_0000, 1, 1, 0);
    wr_reg(3'd0, 64'h8002_0000);
    send("R2 enabled again", 64'h0790_0000, 1, 1, 0);
  endtask

  task automatic t_index;
    wr_reg(3'd1, 64'h0000_0020_0000_000B);
    send("R6 idx11", 64'h0000_0020_0000_1000, 1, 1, 0);
    check("R6 idx11 miss", 64'(out_hit), 64'd0);
    wr_reg(3'd1, 64'h0000_0020_0000_000C);
    send("R6 idx12", 64'h0000_0020_0000_2ABC, 1, 1, 0);
    check("R6 idx12 group", 64'(out_group), 64'd2);
  endtask

  task automatic t_masks;
    wr_reg(3'd2, 64'h5);
    send("R7 rcv clear", 64'h0000_0020_0000_1000, 1, 1, 1);
    check("R7 dropped", 64'(out_fwd), 64'd0);
    wr_reg(3'd3, 64'h1);
    send("R8 block all", 64'h0000_0020_0000_0010, 1, 1, 1);
    check("R8 dropped", 64'(out_fwd), 64'd0);
    wr_reg(3'd3, 64'h0);
    wr_reg(3'd4, 64'h4);
    send("R9 untranslated", 64'h0000_0020_0000_2000, 1, 0, 1);
    check("R9 dropped", 64'(out_fwd), 64'd0);
    send("R9 translated", 64'h0000_0020_0000_2000, 1, 1, 0);
    check("R9 kept", 64'(out_fwd), 64'd1);
    wr_reg(3'd4, 64'h0);
  endtask

  task automatic t_overlay;
    wr_reg(3'd2, 64'h7);
    wr_reg(3'd5, 64'hABCD_0000_1234_5605);
    send("R10 size5", 64'h0000_0020_0000_1FFF, 1, 1, 0);
    check("R10 size5 unchanged", out_addr, 64'h0000_0020_0000_1FFF);
    wr_reg(3'd5, 64'hABCD_0000_1234_5606);
    send("R10 size6", 64'h0000_0020_0000_1FFF, 1, 1, 0);
    check("R10 size6 spliced", out_addr, 64'hABCD_0000_1234_563F);
    wr_reg(3'd5, 64'h8000_0000_0000_003F);
    send("R10 size63", 64'h0000_0020_0000_1FFF, 1, 1, 0);
    check("R10 size63 spliced", out_addr, 64'h8000_0020_0000_1FFF);
    wr_reg(3'd5, 64'h0);
  endtask

  task automatic t_same_cycle;
    bit h, f; int g; logic [63:0] oa;
    ref_model(64'h0000_0020_0000_0040, 1, 1, 1, h, g, f, oa);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 64'h0;
    hdr_valid = 1'b1; hdr_addr = 64'h0000_0020_0000_0040; hdr_write = 1'b1;
    hdr_translated = 1'b1; uc_route = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; hdr_valid = 1'b0;
    shadow(3'd0, 64'h0);
    check("R12 old setting used", 64'(out_hit), 64'(h));
    send("R12 new setting", 64'h0000_0020_0000_0040, 1, 1, 1);
    check("R12 now miss", 64'(out_hit), 64'd0);
  endtask

  task automatic t_full_count;
    wr_reg(3'd0, 64'h803F_0000);
    wr_reg(3'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    send("R5 group63", 64'h0000_0020_0003_F000, 1, 1, 0);
    check("R5 group63 num", 64'(out_group), 64'd63);
    send("R5 group64 miss", 64'h0000_0020_0004_0000, 1, 1, 0);
  endtask

  initial begin
    shadow(3'd0, 0); shadow(3'd1, 0); shadow(3'd2, 0);
    shadow(3'd3, 0); shadow(3'd4, 0); shadow(3'd5, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_groups();
    t_conditions();
    t_index();
    t_masks();
    t_overlay();
    t_same_cycle();
    t_full_count();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule